// File: doc/BRIEF.md
# Indirect Branch Landing Guard

This block sits beside the retire stage of an in-order core and checks that indirect control transfers land only on instructions marked as valid targets. Each retired instruction arrives as a pre-decoded descriptor: a class code, the register that holds a branch target, whether a load writes the PC, the load's base register and writeback flag, a landing marker, a no-tracking marker and a tag.

An eligible indirect transfer arms a single pending bit. The next valid instruction must be a landing instruction, which disarms the bit. If any other instruction arrives first, the block pulses a usage fault for one cycle, clears the bit and records that instruction's tag. An enable input turns the whole check off.

Top module: `bt_land_guard`

## Requirements
- R1: After synchronous reset, `pend_o`, `fault_o` and `fault_tag_o` are all zero.
- R2: Class code 1 (branch with link and exchange, both security variants) sets the pending bit for any target register.
- R3: Class code 2 (branch and exchange, both security variants) sets the pending bit only when `ins_treg_i` is not 14, the link register.
- R4: Class codes 3 (register-offset load) and 4 (literal load) set the pending bit when `ins_pc_dest_i` is 1, and not when it is 0.
- R5: Class codes 5 (immediate-offset load) and 6 (load-multiple, increment-after or decrement-before) with `ins_pc_dest_i` high set the pending bit unless `ins_base_i` is 13, the SP, and `ins_wback_i` is 1 at the same time.
- R6: An instruction with `ins_notrack_i` high never sets the pending bit.
- R7: A valid, enabled instruction that is not a landing instruction, arriving while the pending bit is 1, raises `fault_o` for exactly the following cycle. It also clears the pending bit and loads its tag into `fault_tag_o`. This holds even if that instruction would itself set the bit.
- R8: The landing instructions are any descriptor with `ins_land_i` high, and class code 7, which signs the return address with the SP as context. A landing instruction arriving while the bit is 1 clears it without a fault.
- R9: A landing instruction arriving while the pending bit is 0 changes no output.
- R10: While `en_i` is low, the pending bit reads 0 on the next cycle and no fault is raised.
- R11: Cycles with `ins_valid_i` low leave the pending bit unchanged.
- R12: `fault_tag_o` keeps its value until the next fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable for the landing check |
| ins_valid_i | input | 1 | Descriptor valid this cycle |
| ins_class_i | input | 3 | Instruction class code |
| ins_treg_i | input | REG_W | Register holding the branch target |
| ins_pc_dest_i | input | 1 | Load writes the PC |
| ins_base_i | input | REG_W | Load base register |
| ins_wback_i | input | 1 | Load writes back its base |
| ins_land_i | input | 1 | Instruction is a landing marker |
| ins_notrack_i | input | 1 | Branch carries the no-tracking marker |
| ins_tag_i | input | TAG_W | Instruction tag |
| pend_o | output | 1 | Pending landing bit |
| fault_o | output | 1 | One-cycle usage fault pulse |
| fault_tag_o | output | TAG_W | Tag of the last faulting instruction |

## Verification
The bench goes after the register exceptions. A branch and exchange through the link register must not arm the bit, and neither must an SP-based load with writeback. A design that ignores either exception would later fault on ordinary returns and stack pops. The bench also sends one arming instruction directly after another. A design that lets the second one re-arm the bit, instead of faulting on it, would let an attacker chain indirect branches. Idle and disabled cycles are placed between a branch and its landing, and a stray landing is sent while the bit is clear. These catch a design whose bit decays, survives the enable going low, or whose fault tag moves without a fault.

// File: rtl/btlg_pkg.sv
package btlg_pkg;

    localparam int DEF_REG_W = 4;
    localparam int DEF_LR    = 14;
    localparam int DEF_SP    = 13;

    typedef enum logic [2:0] {
        OPC_OTHER  = 3'd0,
        OPC_BRLX   = 3'd1,
        OPC_BRX    = 3'd2,
        OPC_LDREG  = 3'd3,
        OPC_LDLIT  = 3'd4,
        OPC_LDIMM  = 3'd5,
        OPC_LDMULT = 3'd6,
        OPC_SIGNRA = 3'd7
    } opc_e;

    typedef struct packed {
        logic pend;
        logic fault;
    } guard_st_t;

    function automatic logic is_plain_load(opc_e c);
        return (c == OPC_LDREG) || (c == OPC_LDLIT);
    endfunction

    function automatic logic is_base_load(opc_e c);
        return (c == OPC_LDIMM) || (c == OPC_LDMULT);
    endfunction

endpackage

// File: rtl/btlg_set_rules.sv
module btlg_set_rules
    import btlg_pkg::*;
#(
    parameter int REG_W  = DEF_REG_W,
    parameter int LR_IDX = DEF_LR,
    parameter int SP_IDX = DEF_SP
) (
    input  opc_e             opc,
    input  logic [REG_W-1:0] treg,
    input  logic             pc_dest,
    input  logic [REG_W-1:0] base,
    input  logic             wback,
    input  logic             notrack,
    output logic             want_set
);
    localparam logic [REG_W-1:0] LR_V = LR_IDX[REG_W-1:0];
    localparam logic [REG_W-1:0] SP_V = SP_IDX[REG_W-1:0];

    logic sp_wb;
    logic raw;

    always_comb begin
        sp_wb = (base == SP_V) && wback;
        unique case (opc)
            OPC_BRLX:              raw = 1'b1;
            OPC_BRX:               raw = (treg != LR_V);
            OPC_LDREG, OPC_LDLIT:  raw = pc_dest;
            OPC_LDIMM, OPC_LDMULT: raw = pc_dest && !sp_wb;
            default:               raw = 1'b0;
        endcase
        want_set = raw && !notrack;
    end
endmodule

// File: rtl/btlg_land_detect.sv
module btlg_land_detect
    import btlg_pkg::*;
(
    input  opc_e opc,
    input  logic land_flag,
    output logic is_land
);
    always_comb is_land = land_flag || (opc == OPC_SIGNRA);
endmodule

// File: rtl/btlg_state.sv
module btlg_state
    import btlg_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             valid,
    input  logic             want_set,
    input  logic             is_land,
    input  logic [TAG_W-1:0] tag,
    output logic             pend,
    output logic             fault,
    output logic [TAG_W-1:0] fault_tag
);
    guard_st_t        st_q, st_d;
    logic [TAG_W-1:0] tag_q, tag_d;

    always_comb begin
        st_d.pend  = st_q.pend;
        st_d.fault = 1'b0;
        tag_d      = tag_q;
        if (!en) begin
            st_d.pend = 1'b0;
        end else if (valid) begin
            if (st_q.pend) begin
                st_d.pend = 1'b0;
                if (!is_land) begin
                    st_d.fault = 1'b1;
                    tag_d      = tag;
                end
            end else if (want_set) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            tag_q <= '0;
        end else begin
            st_q  <= st_d;
            tag_q <= tag_d;
        end
    end

    assign pend      = st_q.pend;
    assign fault     = st_q.fault;
    assign fault_tag = tag_q;
endmodule

// File: rtl/bt_land_guard.sv
module bt_land_guard
    import btlg_pkg::*;
#(
    parameter int REG_W  = DEF_REG_W,
    parameter int TAG_W  = 8,
    parameter int LR_IDX = DEF_LR,
    parameter int SP_IDX = DEF_SP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             ins_valid_i,
    input  logic [2:0]       ins_class_i,
    input  logic [REG_W-1:0] ins_treg_i,
    input  logic             ins_pc_dest_i,
    input  logic [REG_W-1:0] ins_base_i,
    input  logic             ins_wback_i,
    input  logic             ins_land_i,
    input  logic             ins_notrack_i,
    input  logic [TAG_W-1:0] ins_tag_i,
    output logic             pend_o,
    output logic             fault_o,
    output logic [TAG_W-1:0] fault_tag_o
);
    opc_e opc;
    logic want_set;
    logic is_land;

    assign opc = opc_e'(ins_class_i);

    btlg_set_rules #(.REG_W(REG_W), .LR_IDX(LR_IDX), .SP_IDX(SP_IDX)) rules_i (
        .opc(opc), .treg(ins_treg_i), .pc_dest(ins_pc_dest_i),
        .base(ins_base_i), .wback(ins_wback_i), .notrack(ins_notrack_i),
        .want_set(want_set)
    );

    btlg_land_detect land_i (
        .opc(opc), .land_flag(ins_land_i), .is_land(is_land)
    );

    btlg_state #(.TAG_W(TAG_W)) state_i (
        .clk(clk), .rst(rst), .en(en_i), .valid(ins_valid_i),
        .want_set(want_set), .is_land(is_land), .tag(ins_tag_i),
        .pend(pend_o), .fault(fault_o), .fault_tag(fault_tag_o)
    );
endmodule

// File: rtl/btlg_chk.sv
module btlg_chk #(
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             ins_valid_i,
    input logic             ins_land_i,
    input logic [2:0]       ins_class_i,
    input logic             pend_o,
    input logic             fault_o,
    input logic [TAG_W-1:0] fault_tag_o
);
    // R7: a fault only follows a valid enabled instruction seen while pending
    p_fault_cause_r7: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> $past(pend_o && ins_valid_i && en_i));

    // R7: fault leaves the bit clear
    p_fault_clears_r7: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !pend_o);

    // R8: landing while pending clears without fault
    p_land_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (en_i && ins_valid_i && pend_o && (ins_land_i || ins_class_i == 3'd7))
        |=> (!pend_o && !fault_o));

    // R10: disabled means quiet
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!pend_o && !fault_o));

    // R11: idle cycles keep the bit
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (en_i && !ins_valid_i) |=> (pend_o == $past(pend_o)));

    // R12: tag only moves with a fault
    p_tag_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !fault_o |-> $stable(fault_tag_o));
endmodule

bind bt_land_guard btlg_chk #(.TAG_W(TAG_W)) chk_i (
    .clk(clk), .rst(rst), .en_i(en_i), .ins_valid_i(ins_valid_i),
    .ins_land_i(ins_land_i), .ins_class_i(ins_class_i), .pend_o(pend_o),
    .fault_o(fault_o), .fault_tag_o(fault_tag_o)
);

// File: tb/bt_land_guard_tb_top.sv
module bt_land_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       en_i;
    logic       ins_valid_i;
    logic [2:0] ins_class_i;
    logic [3:0] ins_treg_i;
    logic       ins_pc_dest_i;
    logic [3:0] ins_base_i;
    logic       ins_wback_i;
    logic       ins_land_i;
    logic       ins_notrack_i;
    logic [7:0] ins_tag_i;
    logic       pend_o;
    logic       fault_o;
    logic [7:0] fault_tag_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    bt_land_guard dut_i (
        .clk(clk), .rst(rst), .en_i(en_i), .ins_valid_i(ins_valid_i),
        .ins_class_i(ins_class_i), .ins_treg_i(ins_treg_i),
        .ins_pc_dest_i(ins_pc_dest_i), .ins_base_i(ins_base_i),
        .ins_wback_i(ins_wback_i), .ins_land_i(ins_land_i),
        .ins_notrack_i(ins_notrack_i), .ins_tag_i(ins_tag_i),
        .pend_o(pend_o), .fault_o(fault_o), .fault_tag_o(fault_tag_o)
    );

    typedef struct packed {
        logic [2:0] cls;
        logic [3:0] treg;
        logic       pcd;
        logic [3:0] base;
        logic       wb;
        logic       nt;
        logic       exp_set;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{3'd1, 4'd3,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 4'd2},  // R2
        '{3'd1, 4'd14, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 4'd2},  // R2 via LR
        '{3'd2, 4'd5,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 4'd3},  // R3
        '{3'd2, 4'd14, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 4'd3},  // R3 LR exempt
        '{3'd3, 4'd0,  1'b1, 4'd1,  1'b0, 1'b0, 1'b1, 4'd4},  // R4
        '{3'd3, 4'd0,  1'b0, 4'd1,  1'b0, 1'b0, 1'b0, 4'd4},  // R4 no pc
        '{3'd4, 4'd0,  1'b1, 4'd0,  1'b1, 1'b0, 1'b1, 4'd4},  // R4 literal
        '{3'd5, 4'd0,  1'b1, 4'd5,  1'b1, 1'b0, 1'b1, 4'd5},  // R5
        '{3'd5, 4'd0,  1'b1, 4'd13, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 sp+wb
        '{3'd5, 4'd0,  1'b1, 4'd13, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 sp no wb
        '{3'd6, 4'd0,  1'b1, 4'd13, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 multi sp+wb
        '{3'd6, 4'd0,  1'b1, 4'd2,  1'b1, 1'b0, 1'b1, 4'd5},  // R5 multi
        '{3'd6, 4'd0,  1'b0, 4'd2,  1'b1, 1'b0, 1'b0, 4'd5},  // R5 no pc
        '{3'd1, 4'd3,  1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 4'd6},  // R6
        '{3'd2, 4'd2,  1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 4'd6},  // R6
        '{3'd0, 4'd0,  1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 4'd2}   // plain op
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] c, logic [3:0] tr, logic pcd, logic [3:0] b,
                         logic wb, logic ld, logic nt, logic [7:0] tg);
        ins_valid_i = 1'b1; ins_class_i = c; ins_treg_i = tr; ins_pc_dest_i = pcd;
        ins_base_i = b; ins_wback_i = wb; ins_land_i = ld; ins_notrack_i = nt;
        ins_tag_i = tg;
        @(negedge clk);
    endtask

    task automatic idle();
        ins_valid_i = 1'b0; ins_class_i = 3'd0; ins_land_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; en_i = 1'b1;
        ins_valid_i = 0; ins_class_i = 0; ins_treg_i = 0; ins_pc_dest_i = 0;
        ins_base_i = 0; ins_wback_i = 0; ins_land_i = 0; ins_notrack_i = 0;
        ins_tag_i = 0;
        repeat (3) @(negedge clk);
        check("R1 pend", pend_o, 0);
        check("R1 fault", fault_o, 0);
        check("R1 tag", fault_tag_o, 0);
        rst = 1'b0;
        idle();

        for (int i = 0; i < NV; i++) begin
            issue(VT[i].cls, VT[i].treg, VT[i].pcd, VT[i].base, VT[i].wb, 1'b0,
                  VT[i].nt, 8'(i));
            check($sformatf("R%0d vec%0d pend", VT[i].req, i), pend_o, VT[i].exp_set);
            check($sformatf("R%0d vec%0d nofault", VT[i].req, i), fault_o, 0);
            if (VT[i].exp_set) begin
                issue(3'd0, 0, 0, 0, 0, 1'b1, 0, 8'hEE);
                check("R8 land clears", pend_o, 0);
                check("R8 land no fault", fault_o, 0);
            end
        end

        // R7 fault on non-landing
        issue(3'd1, 4'd1, 0, 0, 0, 0, 0, 8'h10);
        issue(3'd0, 0, 0, 0, 0, 0, 0, 8'h5A);
        check("R7 fault", fault_o, 1);
        check("R7 pend cleared", pend_o, 0);
        check("R7 tag", fault_tag_o, 8'h5A);
        idle();
        check("R7 single pulse", fault_o, 0);
        check("R12 tag held", fault_tag_o, 8'h5A);

        // R8 signing class lands
        issue(3'd2, 4'd4, 0, 0, 0, 0, 0, 8'h11);
        issue(3'd7, 0, 0, 0, 0, 0, 0, 8'h12);
        check("R8 sign clears", pend_o, 0);
        check("R8 sign no fault", fault_o, 0);
        check("R12 tag after landing", fault_tag_o, 8'h5A);

        // R7 setter while pending faults, no rearm
        issue(3'd1, 4'd1, 0, 0, 0, 0, 0, 8'h20);
        issue(3'd1, 4'd1, 0, 0, 0, 0, 0, 8'h44);
        check("R7 chained fault", fault_o, 1);
        check("R7 chained no rearm", pend_o, 0);
        check("R12 tag updated", fault_tag_o, 8'h44);

        // R9 landing while clear
        issue(3'd0, 0, 0, 0, 0, 1'b1, 0, 8'h99);
        check("R9 pend", pend_o, 0);
        check("R9 fault", fault_o, 0);
        check("R9 tag", fault_tag_o, 8'h44);

        // R11 idle hold
        issue(3'd1, 4'd1, 0, 0, 0, 0, 0, 8'h30);
        for (int k = 0; k < 3; k++) begin
            idle();
            check("R11 hold", pend_o, 1);
        end
        issue(3'd0, 0, 0, 0, 0, 1'b1, 0, 8'h31);
        check("R11 then land", pend_o, 0);
        check("R11 no fault", fault_o, 0);

        // R10 disable
        issue(3'd1, 4'd1, 0, 0, 0, 0, 0, 8'h40);
        en_i = 1'b0;
        issue(3'd0, 0, 0, 0, 0, 0, 0, 8'h41);
        check("R10 pend dropped", pend_o, 0);
        check("R10 no fault", fault_o, 0);
        issue(3'd1, 4'd1, 0, 0, 0, 0, 0, 8'h42);
        check("R10 no set", pend_o, 0);
        en_i = 1'b1;
        issue(3'd0, 0, 0, 0, 0, 0, 0, 8'h43);
        check("R10 no late fault", fault_o, 0);
        check("R12 tag after disable", fault_tag_o, 8'h44);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule